// File: doc/BRIEF.md
# Write-back word cache with cacheable-window control

This block is a 16 KB direct-mapped data cache that sits between a 32-bit processor-side request port and a plain 32-bit memory port. Every line holds a single 32-bit word, so a miss costs exactly one memory read. When the victim line is dirty, the miss first costs one memory write to save that line. Write hits stay inside the cache and only set the line's dirty bit. Memory is updated when the line is evicted or when a flush walks the arrays.

A configuration input sets which physical addresses may be cached. The first megabyte is always cacheable. An 8-bit count then extends the cacheable window upward in 64 KB steps. The tags hold only 24 address bits, so nothing at or above 16 MB is ever cached, whatever the count is. Requests outside the window, and every request while the enable input is low, go to memory unchanged and leave the arrays alone.

A flush request makes the block step through every line. It writes each dirty line back to memory, clears all valid bits, and then raises a one-cycle done pulse.

Top module: `cwb_cache`

## Requirements
- R1: After reset, cpu_ack, flush_done and mem_req are low and every line is invalid, so the first read of any cacheable address produces one memory read.
- R2: A write that hits updates only the cached word and marks the line dirty. No memory write occurs, and a later read of that address returns the new word with no memory traffic.
- R3: On a write hit, cpu_be bit i selects byte lane i (data bits 8i+7 down to 8i) to take the new data; the other lanes keep their cached bytes.
- R4: A cacheable read miss performs one memory read at the word-aligned address (the two low bits forced to zero) and installs the word. A repeated read of the same address is then served with no memory traffic.
- R5: A miss whose line (index = address bits 13:2) holds a valid dirty word of another tag first writes that old word to its own address with all byte enables set. Only then does it read the new word. cpu_ack is raised only after the fill completes.
- R6: A cacheable write miss reads the word from memory, merges the written bytes under cpu_be, and leaves the line dirty. Memory still holds the old word afterwards.
- R7: An address is cacheable only if it is below 1 MB + N×64 KB, with N = cfg_blocks, and also below 16 MB. With N = 0 only the first megabyte qualifies.
- R8: An uncacheable read or write is issued to memory with the request's exact address, data and byte enables, and it allocates no line. A repeated uncacheable read therefore goes to memory again.
- R9: While cfg_en is low, every request is handled as uncacheable.
- R10: A flush writes every dirty line back to memory and clears every valid bit. flush_done is then high for exactly one cycle, and later reads miss.
- R11: Once mem_req is high, mem_req, mem_we, mem_addr, mem_wdata and mem_be stay unchanged until a cycle with mem_ack high.
- R12: cpu_ack and flush_done are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Cache enable; when low, lookup and allocation are off |
| cfg_blocks | input | 8 | Number of cacheable 64 KB blocks above 1 MB |
| cpu_req | input | 1 | Request, held until cpu_ack and then dropped |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_be | input | 4 | Byte enables, bit i for data bits 8i+7:8i |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read data, valid with cpu_ack |
| flush_req | input | 1 | Flush request, held until flush_done |
| flush_done | output | 1 | One-cycle pulse when the flush is complete |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | Memory write select |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_be | output | 4 | Memory byte enables |
| mem_ack | input | 1 | One-cycle memory completion |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |

## Verification
Some properties are checked on every cycle: the memory-port hold rule, the pulse shape of both completion outputs, and full byte enables on every victim write. The checks also confirm that fills never target addresses at or above 16 MB and that no valid line remains when flush_done fires. Other behaviour only the bench scenarios can show, because it depends on the contents of the arrays and on memory traffic. This covers write hits that keep memory stale, byte-lane merging, the victim write coming before the refill, and the exact window edges for several block counts. It also covers pass-through that allocates nothing and the write-back of each dirty line, including the last index, by a flush.

// File: rtl/cwb_pkg.sv
package cwb_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_LOOK,
      S_UNC,
      S_WB,
      S_FILL,
      S_FL_SCAN,
      S_FL_WB,
      S_HOLD
   } cwb_state_e;
endpackage

// File: rtl/cwb_region.sv
module cwb_region #(
   parameter int ADDR_W  = 32,
   parameter int SPAN_W  = 24,
   parameter int BASE_W  = 20,
   parameter int BLOCK_W = 16,
   parameter int CNT_W   = 8
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [CNT_W-1:0]  blocks,
   output logic              cacheable
);
   localparam int LW = ADDR_W + 1;
   localparam logic [LW-1:0] BASE_LIM = LW'(1) << BASE_W;

   if (!(BLOCK_W < BASE_W && BASE_W < SPAN_W && SPAN_W < ADDR_W)) begin : g_bad_widths
      $error("cwb_region: need BLOCK_W < BASE_W < SPAN_W < ADDR_W");
   end

   logic [LW-1:0] limit;
   logic          in_span;

   always_comb begin
      limit   = BASE_LIM + (LW'(blocks) << BLOCK_W);
      in_span = (addr[ADDR_W-1:SPAN_W] == '0);
      cacheable = in_span && ({1'b0, addr} < limit);
   end
endmodule

// File: rtl/cwb_merge.sv
module cwb_merge #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0]   old_w,
   input  logic [DATA_W-1:0]   new_w,
   input  logic [DATA_W/8-1:0] be,
   output logic [DATA_W-1:0]   merged
);
   localparam int BYTES = DATA_W / 8;

   if (DATA_W % 8 != 0) begin : g_bad_width
      $error("cwb_merge: DATA_W must be a multiple of 8");
   end

   for (genvar b = 0; b < BYTES; b++) begin : g_lane
      assign merged[b*8 +: 8] = be[b] ? new_w[b*8 +: 8] : old_w[b*8 +: 8];
   end
endmodule

// File: rtl/cwb_store.sv
module cwb_store #(
   parameter int LINES  = 4096,
   parameter int TAG_W  = 10,
   parameter int DATA_W = 32,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              rd_valid,
   output logic              rd_dirty,
   output logic [TAG_W-1:0]  rd_tag,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic              wr_valid,
   input  logic              wr_dirty,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [DATA_W-1:0] wr_data,
   output logic              any_valid
);
   if (LINES != (1 << IDX_W)) begin : g_bad_lines
      $error("cwb_store: LINES must be a power of two");
   end

   logic [LINES-1:0]  valid_q;
   logic [LINES-1:0]  dirty_q;
   logic [TAG_W-1:0]  tag_mem  [LINES];
   logic [DATA_W-1:0] data_mem [LINES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         dirty_q <= '0;
      end else if (wr_en) begin
         valid_q[wr_idx] <= wr_valid;
         dirty_q[wr_idx] <= wr_dirty;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_mem[wr_idx]  <= wr_tag;
         data_mem[wr_idx] <= wr_data;
      end
   end

   always_comb begin
      rd_valid  = valid_q[rd_idx];
      rd_dirty  = dirty_q[rd_idx];
      rd_tag    = tag_mem[rd_idx];
      rd_data   = data_mem[rd_idx];
      any_valid = |valid_q;
   end
endmodule

// File: rtl/cwb_cache.sv
module cwb_cache
   import cwb_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int CACHE_BYTES = 16384,
   parameter int SPAN_W      = 24,
   parameter int BASE_W      = 20,
   parameter int BLOCK_W     = 16,
   parameter int CNT_W       = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_en,
   input  logic [CNT_W-1:0]     cfg_blocks,
   input  logic                 cpu_req,
   input  logic                 cpu_we,
   input  logic [ADDR_W-1:0]    cpu_addr,
   input  logic [DATA_W-1:0]    cpu_wdata,
   input  logic [DATA_W/8-1:0]  cpu_be,
   output logic                 cpu_ack,
   output logic [DATA_W-1:0]    cpu_rdata,
   input  logic                 flush_req,
   output logic                 flush_done,
   output logic                 mem_req,
   output logic                 mem_we,
   output logic [ADDR_W-1:0]    mem_addr,
   output logic [DATA_W-1:0]    mem_wdata,
   output logic [DATA_W/8-1:0]  mem_be,
   input  logic                 mem_ack,
   input  logic [DATA_W-1:0]    mem_rdata
);
   localparam int BYTES = DATA_W / 8;
   localparam int OFF_W = $clog2(BYTES);
   localparam int LINES = CACHE_BYTES / BYTES;
   localparam int IDX_W = $clog2(LINES);
   localparam int TAG_W = SPAN_W - IDX_W - OFF_W;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINES - 1);

   if (CACHE_BYTES != (1 << $clog2(CACHE_BYTES))) begin : g_bad_size
      $error("cwb_cache: CACHE_BYTES must be a power of two");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("cwb_cache: SPAN_W too small for the cache size");
   end

   cwb_state_e st;
   logic [ADDR_W-1:0] r_addr;
   logic              r_we;
   logic [DATA_W-1:0] r_wdata;
   logic [BYTES-1:0]  r_be;
   logic [IDX_W-1:0]  fidx;

   logic [IDX_W-1:0]  r_idx;
   logic [TAG_W-1:0]  r_tag;
   logic [IDX_W-1:0]  rd_idx;
   logic              rd_valid, rd_dirty, any_valid;
   logic [TAG_W-1:0]  rd_tag;
   logic [DATA_W-1:0] rd_data;
   logic              lw_en, lw_valid, lw_dirty;
   logic [IDX_W-1:0]  lw_idx;
   logic [TAG_W-1:0]  lw_tag;
   logic [DATA_W-1:0] lw_data;
   logic [DATA_W-1:0] hit_merged, fill_merged;
   logic              cacheable, use_cache, hit, flushing;
   logic [ADDR_W-1:0] victim_addr, word_addr;

   assign r_idx = r_addr[IDX_W+OFF_W-1:OFF_W];
   assign r_tag = r_addr[SPAN_W-1:IDX_W+OFF_W];

   cwb_region #(
      .ADDR_W(ADDR_W), .SPAN_W(SPAN_W), .BASE_W(BASE_W),
      .BLOCK_W(BLOCK_W), .CNT_W(CNT_W)
   ) region_i (
      .addr(r_addr), .blocks(cfg_blocks), .cacheable(cacheable)
   );

   cwb_merge #(.DATA_W(DATA_W)) hit_merge_i (
      .old_w(rd_data), .new_w(r_wdata), .be(r_be), .merged(hit_merged)
   );

   cwb_merge #(.DATA_W(DATA_W)) fill_merge_i (
      .old_w(mem_rdata), .new_w(r_wdata), .be(r_be), .merged(fill_merged)
   );

   cwb_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) store_i (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_dirty(rd_dirty),
      .rd_tag(rd_tag), .rd_data(rd_data),
      .wr_en(lw_en), .wr_idx(lw_idx), .wr_valid(lw_valid), .wr_dirty(lw_dirty),
      .wr_tag(lw_tag), .wr_data(lw_data), .any_valid(any_valid)
   );

   always_comb begin
      flushing    = (st == S_FL_SCAN) || (st == S_FL_WB);
      rd_idx      = flushing ? fidx : r_idx;
      use_cache   = cfg_en && cacheable;
      hit         = rd_valid && (rd_tag == r_tag);
      victim_addr = {{(ADDR_W-SPAN_W){1'b0}}, rd_tag, rd_idx, {OFF_W{1'b0}}};
      word_addr   = {r_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
   end

   // line write port: hit update, fill install, flush clear
   always_comb begin
      lw_en    = 1'b0;
      lw_valid = 1'b0;
      lw_dirty = 1'b0;
      lw_idx   = r_idx;
      lw_tag   = r_tag;
      lw_data  = r_wdata;
      case (st)
         S_LOOK: begin
            if (use_cache && hit && r_we) begin
               lw_en    = 1'b1;
               lw_valid = 1'b1;
               lw_dirty = 1'b1;
               lw_data  = hit_merged;
            end
         end
         S_FILL: begin
            if (mem_ack) begin
               lw_en    = 1'b1;
               lw_valid = 1'b1;
               lw_dirty = r_we;
               lw_data  = r_we ? fill_merged : mem_rdata;
            end
         end
         S_FL_SCAN, S_FL_WB: begin
            if ((st == S_FL_SCAN && !(rd_valid && rd_dirty)) || (st == S_FL_WB && mem_ack)) begin
               lw_en   = 1'b1;
               lw_idx  = fidx;
               lw_tag  = rd_tag;
               lw_data = rd_data;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st         <= S_IDLE;
         r_addr     <= '0;
         r_we       <= 1'b0;
         r_wdata    <= '0;
         r_be       <= '0;
         fidx       <= '0;
         cpu_ack    <= 1'b0;
         cpu_rdata  <= '0;
         flush_done <= 1'b0;
         mem_req    <= 1'b0;
         mem_we     <= 1'b0;
         mem_addr   <= '0;
         mem_wdata  <= '0;
         mem_be     <= '0;
      end else begin
         cpu_ack    <= 1'b0;
         flush_done <= 1'b0;
         case (st)
            S_IDLE: begin
               if (flush_req) begin
                  fidx <= '0;
                  st   <= S_FL_SCAN;
               end else if (cpu_req) begin
                  r_addr  <= cpu_addr;
                  r_we    <= cpu_we;
                  r_wdata <= cpu_wdata;
                  r_be    <= cpu_be;
                  st      <= S_LOOK;
               end
            end
            S_LOOK: begin
               if (!use_cache) begin
                  mem_req   <= 1'b1;
                  mem_we    <= r_we;
                  mem_addr  <= r_addr;
                  mem_wdata <= r_wdata;
                  mem_be    <= r_be;
                  st        <= S_UNC;
               end else if (hit) begin
                  cpu_rdata <= rd_data;
                  cpu_ack   <= 1'b1;
                  st        <= S_HOLD;
               end else if (rd_valid && rd_dirty) begin
                  mem_req   <= 1'b1;
                  mem_we    <= 1'b1;
                  mem_addr  <= victim_addr;
                  mem_wdata <= rd_data;
                  mem_be    <= '1;
                  st        <= S_WB;
               end else begin
                  mem_req  <= 1'b1;
                  mem_we   <= 1'b0;
                  mem_addr <= word_addr;
                  mem_be   <= '1;
                  st       <= S_FILL;
               end
            end
            S_WB: begin
               if (mem_ack) begin
                  mem_we   <= 1'b0;
                  mem_addr <= word_addr;
                  st       <= S_FILL;
               end
            end
            S_FILL, S_UNC: begin
               if (mem_ack) begin
                  mem_req   <= 1'b0;
                  cpu_rdata <= mem_rdata;
                  cpu_ack   <= 1'b1;
                  st        <= S_HOLD;
               end
            end
            S_FL_SCAN: begin
               if (rd_valid && rd_dirty) begin
                  mem_req   <= 1'b1;
                  mem_we    <= 1'b1;
                  mem_addr  <= victim_addr;
                  mem_wdata <= rd_data;
                  mem_be    <= '1;
                  st        <= S_FL_WB;
               end else if (fidx == LAST_IDX) begin
                  flush_done <= 1'b1;
                  st         <= S_HOLD;
               end else begin
                  fidx <= fidx + 1'b1;
               end
            end
            S_FL_WB: begin
               if (mem_ack) begin
                  mem_req <= 1'b0;
                  if (fidx == LAST_IDX) begin
                     flush_done <= 1'b1;
                     st         <= S_HOLD;
                  end else begin
                     fidx <= fidx + 1'b1;
                     st   <= S_FL_SCAN;
                  end
               end
            end
            S_HOLD: begin
               if (!cpu_req && !flush_req) st <= S_IDLE;
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   // R11
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)
                                 && $stable(mem_wdata) && $stable(mem_be)));

   // R12
   ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ack || flush_done) |=> (!cpu_ack && !flush_done));

   // R12
   ack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cpu_ack && flush_done));

   // R5
   victim_full_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && (st == S_WB || st == S_FL_WB)) |-> (mem_we && mem_be == '1));

   // R7
   fill_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_FILL) |-> (mem_addr[ADDR_W-1:SPAN_W] == '0));

   // R10
   flush_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_done |-> !any_valid);
endmodule

// File: tb/cwb_cache_tb_top.sv
`timescale 1ns/1ps
module cwb_cache_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_en = 1'b1;
   logic [7:0]  cfg_blocks = 8'd16;
   logic        cpu_req = 1'b0, cpu_we = 1'b0;
   logic [31:0] cpu_addr = '0, cpu_wdata = '0;
   logic [3:0]  cpu_be = '0;
   logic        cpu_ack;
   logic [31:0] cpu_rdata;
   logic        flush_req = 1'b0;
   logic        flush_done;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic [3:0]  mem_be;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;

   always #2.5 clk = ~clk;

   cwb_cache dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_blocks(cfg_blocks),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_be(cpu_be), .cpu_ack(cpu_ack),
      .cpu_rdata(cpu_rdata), .flush_req(flush_req), .flush_done(flush_done),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(mem_ack),
      .mem_rdata(mem_rdata)
   );

   int n_chk = 0;
   int n_fail = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] seed_word(input int unsigned w);
      return (w * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
   endfunction

   function automatic logic [31:0] merge_be(input logic [31:0] o, input logic [31:0] n, input logic [3:0] be);
      logic [31:0] r;
      r = o;
      for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = n[b*8 +: 8];
      return r;
   endfunction

   // memory model
   logic [31:0] mem_arr [int unsigned];
   logic [31:0] gold    [int unsigned];
   int rd_cnt = 0, wr_cnt = 0, op_seq = 1, rd_seq = 0, wr_seq = 0, lat = 0;
   logic [31:0] last_wa = '0, last_wd = '0, last_ra = '0;
   logic [3:0]  last_wbe = '0;

   function automatic logic [31:0] mem_peek(input logic [31:0] a);
      int unsigned w = a >> 2;
      if (mem_arr.exists(w)) return mem_arr[w];
      return seed_word(w);
   endfunction

   function automatic logic [31:0] gold_peek(input logic [31:0] a);
      int unsigned w = a >> 2;
      if (gold.exists(w)) return gold[w];
      return seed_word(w);
   endfunction

   always @(posedge clk) begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
         if (lat == 2) begin
            lat     <= 0;
            mem_ack <= 1'b1;
            op_seq  <= op_seq + 1;
            if (mem_we) begin
               mem_arr[mem_addr >> 2] = merge_be(mem_peek(mem_addr), mem_wdata, mem_be);
               wr_cnt   <= wr_cnt + 1;
               last_wa  <= mem_addr;
               last_wd  <= mem_wdata;
               last_wbe <= mem_be;
               wr_seq   <= op_seq;
            end else begin
               mem_rdata <= mem_peek(mem_addr);
               rd_cnt    <= rd_cnt + 1;
               last_ra   <= mem_addr;
               rd_seq    <= op_seq;
            end
         end else begin
            lat <= lat + 1;
         end
      end else begin
         lat <= 0;
      end
   end

   // scoreboard
   logic [31:0] exp_q [$];
   bit          isrd_q [$];
   string       tag_q [$];

   always @(negedge clk) begin
      if (rst_n && cpu_ack) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R12 unexpected ack", cpu_rdata, 32'h0);
         end else begin
            logic [31:0] e;
            bit r;
            string t;
            e = exp_q.pop_front();
            r = isrd_q.pop_front();
            t = tag_q.pop_front();
            if (r) chk(cpu_rdata === e, t, cpu_rdata, e);
         end
      end
   end

   task automatic cpu_op(input bit we, input logic [31:0] a, input logic [31:0] d,
                         input logic [3:0] be, input string req);
      int cyc = 0;
      if (we) begin
         gold[a >> 2] = merge_be(gold_peek(a), d, be);
         exp_q.push_back(32'h0);
      end else begin
         exp_q.push_back(gold_peek(a));
      end
      isrd_q.push_back(!we);
      tag_q.push_back(req);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d; cpu_be = be;
      do begin
         @(negedge clk);
         cyc++;
      end while (!cpu_ack && cyc < 200);
      if (cyc >= 200) chk(1'b0, {req, " no ack"}, 32'h0, 32'h1);
      cpu_req = 1'b0;
      @(negedge clk);
   endtask

   task automatic rd_twice(input logic [31:0] a, input int exp_reads, input string req);
      int r0 = rd_cnt;
      cpu_op(1'b0, a, 32'h0, 4'hF, req);
      cpu_op(1'b0, a, 32'h0, 4'hF, req);
      chk(rd_cnt - r0 == exp_reads, req, 32'(rd_cnt - r0), 32'(exp_reads));
   endtask

   task automatic do_flush(output int high_cycles);
      int cyc = 0;
      high_cycles = 0;
      @(negedge clk);
      flush_req = 1'b1;
      do begin
         @(negedge clk);
         cyc++;
      end while (!flush_done && cyc < 20000);
      if (flush_done) high_cycles = 1;
      flush_req = 1'b0;
      @(negedge clk);
      if (flush_done) high_cycles++;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int r0, w0, hc;
      logic [31:0] v;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!cpu_ack && !flush_done && !mem_req, "R1 outputs idle", {29'h0, cpu_ack, flush_done, mem_req}, 32'h0);
      r0 = rd_cnt;
      cpu_op(1'b0, 32'h40, 32'h0, 4'hF, "R1 first read data");
      chk(rd_cnt - r0 == 1, "R1 first read misses", 32'(rd_cnt - r0), 32'd1);
      // R4 repeat read hits
      r0 = rd_cnt;
      cpu_op(1'b0, 32'h40, 32'h0, 4'hF, "R4 hit data");
      chk(rd_cnt == r0, "R4 hit no mem read", 32'(rd_cnt - r0), 32'd0);
      r0 = rd_cnt;
      cpu_op(1'b0, 32'h207, 32'h0, 4'hF, "R4 fill data");
      chk(last_ra == 32'h204, "R4 fill word aligned", last_ra, 32'h204);
      // R2 write hit stays in cache
      w0 = wr_cnt; r0 = rd_cnt;
      cpu_op(1'b1, 32'h40, 32'h1122_3344, 4'hF, "R2 write");
      chk(wr_cnt == w0, "R2 no mem write", 32'(wr_cnt - w0), 32'd0);
      chk(mem_peek(32'h40) == seed_word(32'h10), "R2 memory stale", mem_peek(32'h40), seed_word(32'h10));
      cpu_op(1'b0, 32'h40, 32'h0, 4'hF, "R2 read back");
      chk(rd_cnt == r0, "R2 no mem read", 32'(rd_cnt - r0), 32'd0);
      // R3 byte lanes on hit
      cpu_op(1'b1, 32'h40, 32'hAABB_CCDD, 4'b0101, "R3 write");
      chk(gold_peek(32'h40) == 32'h11BB_33DD, "R3 expected merge", gold_peek(32'h40), 32'h11BB_33DD);
      cpu_op(1'b0, 32'h40, 32'h0, 4'hF, "R3 merged read");
      // R5 dirty victim
      w0 = wr_cnt; r0 = rd_cnt;
      cpu_op(1'b0, 32'h4040, 32'h0, 4'hF, "R5 new word");
      chk(wr_cnt - w0 == 1, "R5 one victim write", 32'(wr_cnt - w0), 32'd1);
      chk(last_wa == 32'h40 && last_wbe == 4'hF, "R5 victim addr/be", last_wa, 32'h40);
      chk(mem_peek(32'h40) == 32'h11BB_33DD, "R5 victim data", mem_peek(32'h40), 32'h11BB_33DD);
      chk(wr_seq < rd_seq, "R5 write before read", 32'(wr_seq), 32'(rd_seq));
      // R6 write miss allocates
      w0 = wr_cnt; r0 = rd_cnt;
      cpu_op(1'b1, 32'h80, 32'h0000_BEEF, 4'b0011, "R6 write");
      chk(rd_cnt - r0 == 1 && wr_cnt == w0, "R6 one read no write", 32'(rd_cnt - r0), 32'd1);
      chk(mem_peek(32'h80) == seed_word(32'h20), "R6 memory stale", mem_peek(32'h80), seed_word(32'h20));
      r0 = rd_cnt;
      cpu_op(1'b0, 32'h80, 32'h0, 4'hF, "R6 merged read");
      chk(rd_cnt == r0, "R6 read hits", 32'(rd_cnt - r0), 32'd0);
      // R7 window edges
      cfg_blocks = 8'd2;
      rd_twice(32'h0011_FFFC, 1, "R7 N=2 last word cached");
      rd_twice(32'h0012_0000, 2, "R7 N=2 limit uncached");
      cfg_blocks = 8'd0;
      rd_twice(32'h0010_0000, 2, "R7 N=0 1MB uncached");
      rd_twice(32'h000F_FFFC, 1, "R7 N=0 below 1MB cached");
      cfg_blocks = 8'd255;
      rd_twice(32'h00FF_FFFC, 1, "R7 N=255 below 16MB cached");
      rd_twice(32'h0100_0000, 2, "R7 16MB never cached");
      cfg_blocks = 8'd16;
      // R8 pass-through
      w0 = wr_cnt;
      cpu_op(1'b1, 32'h0200_0000, 32'h9900_0000, 4'b1000, "R8 write");
      chk(wr_cnt - w0 == 1, "R8 write goes out", 32'(wr_cnt - w0), 32'd1);
      chk(last_wa == 32'h0200_0000 && last_wbe == 4'b1000 && last_wd == 32'h9900_0000,
          "R8 write fields", last_wd, 32'h9900_0000);
      rd_twice(32'h0200_0002, 2, "R8 read not allocated");
      chk(last_ra == 32'h0200_0002, "R8 addr unchanged", last_ra, 32'h0200_0002);
      // R10 flush
      cpu_op(1'b1, 32'h100, 32'hCAFE_0100, 4'hF, "R10 dirty a");
      cpu_op(1'b1, 32'h3FFFC, 32'hCAFE_FFFC, 4'hF, "R10 dirty last index");
      w0 = wr_cnt;
      do_flush(hc);
      chk(hc == 1, "R10 done one cycle", 32'(hc), 32'd1);
      chk(wr_cnt - w0 == 3, "R10 dirty write-backs", 32'(wr_cnt - w0), 32'd3);
      v = gold_peek(32'h80);
      chk(mem_peek(32'h80) == v, "R10 mem 0x80", mem_peek(32'h80), v);
      chk(mem_peek(32'h100) == 32'hCAFE_0100, "R10 mem 0x100", mem_peek(32'h100), 32'hCAFE_0100);
      chk(mem_peek(32'h3FFFC) == 32'hCAFE_FFFC, "R10 mem last index", mem_peek(32'h3FFFC), 32'hCAFE_FFFC);
      r0 = rd_cnt;
      cpu_op(1'b0, 32'h80, 32'h0, 4'hF, "R10 read after flush");
      chk(rd_cnt - r0 == 1, "R10 line invalid", 32'(rd_cnt - r0), 32'd1);
      do_flush(hc);
      // R9 disabled
      cfg_en = 1'b0;
      rd_twice(32'h40, 2, "R9 disabled reads");
      w0 = wr_cnt;
      cpu_op(1'b1, 32'h40, 32'h5555_AAAA, 4'hF, "R9 write");
      chk(wr_cnt - w0 == 1 && mem_peek(32'h40) == 32'h5555_AAAA, "R9 write to memory",
          mem_peek(32'h40), 32'h5555_AAAA);
      cpu_op(1'b0, 32'h40, 32'h0, 4'hF, "R9 read back");
      cfg_en = 1'b1;
      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R12 all acks seen", 32'(exp_q.size()), 32'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule